// File: doc/BRIEF.md
# Asynchronous Serial Port with Control/Status Register

This block is a full-duplex asynchronous serial port of the kind found beside a small embedded processor. A transmitter and a receiver run at the same time. Each takes its bit timing from a tick strobe supplied from outside. The transmitter uses one tick per bit. The receiver uses a tick at sixteen times its bit rate. The two rates may be equal or different.

Software sees two byte-wide locations, chosen by `reg_sel`. The data location loads the transmitter when written and returns the receive holding register when read. The control location combines the frame mode, the address-filter enable, the receive enable, the ninth-bit fields and the two event flags. The receiver is double buffered: a frame shifts in while the previous byte waits in the holding register. A newer accepted frame replaces a byte that has not been read.

Nine-bit frames carry an extra bit that can act as an address marker. With filtering on, frames whose marker is clear are discarded without raising the receive flag. In the eight-bit mode the same filter control discards frames whose stop bit is bad. The interrupt line is raised while either event flag is set.

Top module: `sport_core`

## Requirements
- R1: Control byte layout, bit 7 down to 0: mode high, mode low, filter enable, receive enable, transmit ninth bit, receive ninth bit, transmit-done flag, receive-done flag. Mode 00 is the shift encoding, 01 is 8-bit, and 10 and 11 are 9-bit. `reg_sel`=1 selects control and 0 selects data. Written control bytes read back unchanged. After reset the control and data registers read 0 and `txd` is 1.
- R2: A data write while the transmitter is idle starts a frame on the next `tx_tick`. Each bit lasts one tick period, in this order: start 0, eight data bits LSB first, the transmit ninth bit (9-bit modes only), then stop 1. `txd` is 1 whenever no frame is in progress.
- R3: The transmit-done flag (bit 1) is set on the `tx_tick` that ends the stop bit. It is still 0 during the stop bit. It stays set until software writes it to 0.
- R4: A data write made while a frame is pending or being sent is discarded. No further frame follows.
- R5: The receiver detects a start on a falling edge of `rxd`, seen at `rx_tick16` rate. Each bit is resolved by a 2-of-3 vote over samples 7, 8 and 9 of its sixteen. If the start bit votes 1, the receiver returns to idle without any flag change.
- R6: An accepted frame loads the holding register and sets the receive-done flag (bit 0) at sample 9 of its stop bit. Reading the data location does not disturb the frame being shifted. An accepted frame overwrites an unread byte.
- R7: In the 9-bit modes the received ninth bit goes to bit 2. With filtering on (bit 5 = 1), a frame whose ninth bit is 0 changes neither the flag, bit 2 nor the holding register.
- R8: In the 8-bit mode bit 2 receives the stop bit. With filtering on, a frame with stop bit 0 is discarded. With filtering off, it is accepted.
- R9: While the receive enable (bit 4) is 0, no frame is received. Clearing it during a frame aborts that frame.
- R10: `irq` is 1 exactly when bit 1 or bit 0 is set.
- R11: In mode 00, frames use 8-bit framing, the filter enable has no effect and bit 2 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tick16 | input | 1 | Receive strobe at 16x bit rate |
| tx_tick | input | 1 | Transmit strobe, one per bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| reg_sel | input | 1 | 0 = data location, 1 = control location |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected location |
| irq | output | 1 | Interrupt request |

## Verification
The receive flag, the ninth bit and the holding register change at sample 9 of the stop bit. That is roughly 40 clocks into the stop bit, counting two synchronizer stages and tick alignment. The bench therefore checks them only after the whole stop bit has been driven. The transmit flag is registered on the tick that closes the stop bit. The bench checks that it is still 0 at mid-stop and set 40 clocks later. Transmitted bits are sampled 32 clocks after each bit edge, at mid-bit, starting from the observed falling edge of the start bit.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int DW = 8;            // data bits per frame
  localparam int FW = DW + 3;       // start + data + ninth + stop

  // control byte bit positions
  localparam int CB_MODE_HI = 7;
  localparam int CB_MODE_LO = 6;
  localparam int CB_FILT    = 5;
  localparam int CB_REN     = 4;
  localparam int CB_TXB9    = 3;
  localparam int CB_RXB9    = 2;
  localparam int CB_TI      = 1;
  localparam int CB_RI      = 0;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_8BIT  = 2'b01,
    MODE_9A    = 2'b10,
    MODE_9B    = 2'b11
  } sport_mode_e;

  function automatic logic mode_nine(input logic [1:0] m);
    return m[1];
  endfunction

  // frame bits in send order, index 0 first
  function automatic logic [FW-1:0] tx_frame(input logic [DW-1:0] d,
                                             input logic nine, input logic b9);
    return {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // b9: ninth bit in 9-bit modes, stop bit in 8-bit mode
  function automatic logic rx_accept(input logic [1:0] m, input logic filt,
                                     input logic b9);
    if (m == MODE_SHIFT) return 1'b1;
    return !filt || b9;
  endfunction
endpackage

// File: rtl/sport_tx.sv
module sport_tx
  import sport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_nine,
  input  logic          ld_b9,
  output logic          txd,
  output logic          busy,
  output logic          start_ev,
  output logic          done_ev
);
  localparam int PW = $clog2(FW);
  localparam logic [PW-1:0] LAST9 = PW'(FW - 1);
  localparam logic [PW-1:0] LAST8 = PW'(FW - 2);

  logic [FW-1:0] frame_q;
  logic [PW-1:0] pos_q, last_q, nxt;
  logic          pend_q, send_q, txd_q;

  assign nxt      = pos_q + 1'b1;
  assign start_ev = tick && pend_q && !send_q;
  assign done_ev  = tick && send_q && (pos_q == last_q);
  assign busy     = pend_q | send_q;
  assign txd      = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '1;
      pos_q   <= '0;
      last_q  <= LAST8;
      pend_q  <= 1'b0;
      send_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      // a write is taken only when nothing is queued or in flight
      if (load && !pend_q && !send_q) begin
        frame_q <= tx_frame(ld_data, ld_nine, ld_b9);
        last_q  <= ld_nine ? LAST9 : LAST8;
        pend_q  <= 1'b1;
      end
      if (start_ev) begin
        send_q <= 1'b1;
        pend_q <= 1'b0;
        pos_q  <= '0;
        txd_q  <= frame_q[0];
      end else if (tick && send_q) begin
        if (pos_q == last_q) begin
          send_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          pos_q <= nxt;
          txd_q <= frame_q[nxt];
        end
      end
    end
  end
endmodule

// File: rtl/sport_rx.sv
module sport_rx
  import sport_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_raw,
  output logic          done_ev,
  output logic          false_ev,
  output logic [DW-1:0] data,
  output logic          b9,
  output logic          busy
);
  localparam int CW  = $clog2(OSR);
  localparam int PW  = $clog2(FW);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] S_A   = CW'(MID - 1);
  localparam logic [CW-1:0] S_B   = CW'(MID);
  localparam logic [CW-1:0] S_C   = CW'(MID + 1);
  localparam logic [CW-1:0] S_END = CW'(OSR - 1);
  localparam logic [PW-1:0] LAST9 = PW'(FW - 1);
  localparam logic [PW-1:0] LAST8 = PW'(FW - 2);

  logic          s1_q, s2_q, lvl_q, busy_q;
  logic [CW-1:0] smp_q;
  logic [PW-1:0] pos_q, last;
  logic [1:0]    v_q;
  logic [DW:0]   sh_q;           // data bits plus ninth bit
  logic          vote, mid_ev;

  assign last     = nine ? LAST9 : LAST8;
  assign vote     = vote3(v_q[1], v_q[0], s2_q);
  assign mid_ev   = en && tick16 && busy_q && (smp_q == S_C);
  assign false_ev = mid_ev && (pos_q == '0) && vote;
  assign done_ev  = mid_ev && (pos_q == last);
  assign data     = sh_q[DW-1:0];
  assign b9       = nine ? sh_q[DW] : vote;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      lvl_q  <= 1'b1;
      busy_q <= 1'b0;
      smp_q  <= '0;
      pos_q  <= '0;
      v_q    <= '0;
      sh_q   <= '0;
    end else begin
      s1_q <= rxd_raw;
      s2_q <= s1_q;
      if (tick16) lvl_q <= s2_q;
      if (!en) begin
        busy_q <= 1'b0;                      // abort or stay idle
      end else if (tick16) begin
        if (!busy_q) begin
          if (lvl_q && !s2_q) begin          // falling edge: sample 0 of start
            busy_q <= 1'b1;
            smp_q  <= '0;
            pos_q  <= '0;
          end
        end else begin
          smp_q <= smp_q + 1'b1;
          if (smp_q == S_A) v_q[1] <= s2_q;
          if (smp_q == S_B) v_q[0] <= s2_q;
          if (smp_q == S_C) begin
            if (false_ev || done_ev) busy_q <= 1'b0;
            else if (pos_q != '0) sh_q[pos_q - 1'b1] <= vote;
          end
          if (smp_q == S_END) begin
            smp_q <= '0;
            pos_q <= pos_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sport_core.sv
module sport_core
  import sport_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_tick16,
  input  logic          tx_tick,
  input  logic          rxd,
  output logic          txd,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  logic [7:0]    ctrl_q;
  logic [DW-1:0] hold_q;
  logic [1:0]    mode;
  logic          nine, filt, ren, wr_ctrl, wr_data;
  logic          tx_start, tx_done, tx_busy;
  logic          rx_done, rx_false, rx_busy, rx_b9, rx_keep, rx_drop;
  logic [DW-1:0] rx_data;

  assign mode    = ctrl_q[CB_MODE_HI:CB_MODE_LO];
  assign nine    = mode_nine(mode);
  assign filt    = ctrl_q[CB_FILT];
  assign ren     = ctrl_q[CB_REN];
  assign wr_ctrl = reg_wr && reg_sel;
  assign wr_data = reg_wr && !reg_sel;
  assign rx_keep = rx_done && rx_accept(mode, filt, rx_b9);
  assign rx_drop = rx_done && !rx_keep;

  sport_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .load(wr_data),
    .ld_data(reg_wdata), .ld_nine(nine), .ld_b9(ctrl_q[CB_TXB9]),
    .txd(txd), .busy(tx_busy), .start_ev(tx_start), .done_ev(tx_done)
  );

  sport_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick16(rx_tick16), .en(ren), .nine(nine),
    .rxd_raw(rxd), .done_ev(rx_done), .false_ev(rx_false), .data(rx_data),
    .b9(rx_b9), .busy(rx_busy)
  );

  // later assignments win: a hardware flag set overrides a same-cycle write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hold_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (rx_keep) begin
        hold_q        <= rx_data;
        ctrl_q[CB_RI] <= 1'b1;
        if (mode != MODE_SHIFT) ctrl_q[CB_RXB9] <= rx_b9;
      end
      if (tx_done) ctrl_q[CB_TI] <= 1'b1;
    end
  end

  assign reg_rdata = reg_sel ? ctrl_q : hold_q;
  assign irq       = ctrl_q[CB_TI] | ctrl_q[CB_RI];
endmodule

// File: rtl/sport_core_chk.sv
module sport_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ti,
  input logic       ri,
  input logic       ren,
  input logic       txd,
  input logic       irq,
  input logic       wr_ctrl,
  input logic       tx_start,
  input logic       tx_done,
  input logic       tx_busy,
  input logic       rx_keep,
  input logic       rx_drop,
  input logic       rx_false,
  input logic       rx_busy,
  input logic [7:0] hold
);
  p_tx_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  p_tx_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !txd);
  p_ti_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti) |-> $past(tx_done || wr_ctrl));
  p_ti_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ti) |-> $past(wr_ctrl));
  p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_false |=> !rx_busy);
  p_ri_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(rx_keep || wr_ctrl));
  p_drop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> $stable(hold));
  p_ren_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> !rx_busy);
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(ti) || $rose(ri)));
endmodule

bind sport_core sport_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ti(ctrl_q[1]), .ri(ctrl_q[0]), .ren(ren),
  .txd(txd), .irq(irq), .wr_ctrl(wr_ctrl), .tx_start(tx_start),
  .tx_done(tx_done), .tx_busy(tx_busy), .rx_keep(rx_keep), .rx_drop(rx_drop),
  .rx_false(rx_false), .rx_busy(rx_busy), .hold(hold_q)
);

// File: tb/sport_core_test.sv
module sport_core_test;
  localparam int BIT = 64;   // clocks per bit: tx tick period, 16 rx ticks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_tick16 = 1'b0;
  logic       tx_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [5:0] div = '0;

  sport_core uut (
    .clk(clk), .rst_n(rst_n), .rx_tick16(rx_tick16), .tx_tick(tx_tick),
    .rxd(rxd), .txd(txd), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  // tick strobes change at the falling edge, away from the sampling edge
  always @(negedge clk) begin
    div       <= div + 6'd1;
    rx_tick16 <= (div[1:0] == 2'd3);
    tx_tick   <= (div == 6'd63);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL timeout (all requirements) actual=%0d cycles expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // drive one frame on rxd; each bit held BIT clocks, stop held in full
  task automatic send_rx(input logic [7:0] d, input logic nine, input logic b9,
                         input logic stp);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (nine) begin
      rxd = b9;
      repeat (BIT) @(negedge clk);
    end
    rxd = stp;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v); chk("R1 ctrl reset", 16'(v), 16'h00);
    rd(1'b0, v); chk("R1 data reset", 16'(v), 16'h00);
    chk("R1 txd idle", 16'(txd), 16'h1);
    chk("R10 irq reset", 16'(irq), 16'h0);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] v;
    wr(1'b1, 8'hAC); rd(1'b1, v); chk("R1 ctrl readback", 16'(v), 16'hAC);
    chk("R10 irq off with flags clear", 16'(irq), 16'h0);
    wr(1'b1, 8'h03); rd(1'b1, v); chk("R1 ctrl readback flags", 16'(v), 16'h03);
    chk("R10 irq from flags", 16'(irq), 16'h1);
    wr(1'b1, 8'h00);
  endtask

  // mode: 2-bit mode field; transmit and check each bit at mid-bit
  task automatic t_tx(input logic [1:0] mode, input logic [7:0] d, input logic tb8);
    logic [7:0] v;
    logic nine;
    int n;
    nine = mode[1];
    wr(1'b1, {mode, 2'b00, tb8, 3'b000});
    wr(1'b0, d);
    n = 0;
    while (txd !== 1'b0 && n < 3 * BIT) begin @(negedge clk); n++; end
    chk("R2 start seen", 16'(n < 3 * BIT), 16'h1);
    repeat (BIT / 2) @(negedge clk);
    chk("R2 start bit", 16'(txd), 16'h0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      chk($sformatf("R2 data bit %0d", i), 16'(txd), 16'(d[i]));
    end
    if (nine) begin
      repeat (BIT) @(negedge clk);
      chk("R2 ninth bit", 16'(txd), 16'(tb8));
    end
    repeat (BIT) @(negedge clk);
    chk("R2 stop bit", 16'(txd), 16'h1);
    rd(1'b1, v); chk("R3 TI clear during stop", 16'(v[1]), 16'h0);
    repeat (40) @(negedge clk);
    rd(1'b1, v); chk("R3 TI set after stop", 16'(v[1]), 16'h1);
    chk("R10 irq with TI", 16'(irq), 16'h1);
    repeat (BIT) @(negedge clk);
    rd(1'b1, v); chk("R3 TI sticky", 16'(v[1]), 16'h1);
    wr(1'b1, {mode, 2'b00, tb8, 3'b000});
    rd(1'b1, v); chk("R3 TI cleared by write", 16'(v[1]), 16'h0);
    chk("R10 irq clear", 16'(irq), 16'h0);
  endtask

  task automatic t_tx_busy();
    logic [7:0] v;
    int lows;
    wr(1'b1, 8'h40);
    wr(1'b0, 8'h3C);
    wr(1'b0, 8'hFF);                       // pending: discarded
    while (txd !== 1'b0) @(negedge clk);
    repeat (3 * BIT) @(negedge clk);
    wr(1'b0, 8'h00);                       // in flight: discarded
    repeat (7 * BIT + 40) @(negedge clk);
    rd(1'b1, v); chk("R4 first frame done", 16'(v[1]), 16'h1);
    wr(1'b1, 8'h40);
    lows = 0;
    for (int i = 0; i < 3 * BIT; i++) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    chk("R4 no second frame", 16'(lows), 16'h0);
    rd(1'b1, v); chk("R4 TI stays clear", 16'(v[1]), 16'h0);
  endtask

  task automatic t_rx_basic();
    logic [7:0] v;
    wr(1'b1, 8'h50);                       // 8-bit, REN
    send_rx(8'hA5, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R6 RI set", 16'(v[0]), 16'h1);
    chk("R8 RB8 is stop", 16'(v[2]), 16'h1);
    chk("R10 irq with RI", 16'(irq), 16'h1);
    rd(1'b0, v); chk("R6 data", 16'(v), 16'hA5);
  endtask

  task automatic t_rx_overrun();
    logic [7:0] v;
    logic [7:0] mid;
    wr(1'b1, 8'h50);
    send_rx(8'h12, 1'b0, 1'b0, 1'b1);
    fork
      send_rx(8'hC3, 1'b0, 1'b0, 1'b1);
      begin
        repeat (5 * BIT) @(negedge clk);
        rd(1'b0, mid);
      end
    join
    chk("R6 held byte during next frame", 16'(mid), 16'h12);
    rd(1'b0, v); chk("R6 overrun replaces", 16'(v), 16'hC3);
    rd(1'b1, v); chk("R6 RI after overrun", 16'(v[0]), 16'h1);
  endtask

  task automatic t_false_start();
    logic [7:0] v;
    wr(1'b1, 8'h50);
    @(negedge clk); rxd = 1'b0;
    repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    rd(1'b1, v); chk("R5 false start no RI", 16'(v[0]), 16'h0);
    send_rx(8'h69, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); chk("R5 receiver recovered", 16'(v), 16'h69);
  endtask

  task automatic t_rx_8bit_filter();
    logic [7:0] v;
    wr(1'b1, 8'h70);                       // 8-bit, filter, REN
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);      // bad stop
    repeat (BIT) @(negedge clk);
    rd(1'b1, v); chk("R8 bad stop dropped RI", 16'(v[0]), 16'h0);
    rd(1'b0, v); chk("R8 bad stop data kept", 16'(v), 16'h69);
    wr(1'b1, 8'h54);                       // filter off, RB8 preset 1
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    repeat (BIT) @(negedge clk);
    rd(1'b1, v); chk("R8 bad stop accepted RI", 16'(v[0]), 16'h1);
    chk("R8 RB8 takes stop 0", 16'(v[2]), 16'h0);
    rd(1'b0, v); chk("R8 data accepted", 16'(v), 16'h81);
  endtask

  task automatic t_rx_nine();
    logic [7:0] v;
    wr(1'b1, 8'hB4);                       // 9-bit, filter, REN, RB8=1
    send_rx(8'h5E, 1'b1, 1'b0, 1'b1);
    rd(1'b1, v); chk("R7 filtered no RI", 16'(v[0]), 16'h0);
    chk("R7 filtered RB8 kept", 16'(v[2]), 16'h1);
    rd(1'b0, v); chk("R7 filtered data kept", 16'(v), 16'h81);
    wr(1'b1, 8'hB0);
    send_rx(8'hE7, 1'b1, 1'b1, 1'b1);
    rd(1'b1, v); chk("R7 address frame RI", 16'(v[0]), 16'h1);
    chk("R7 RB8 ninth 1", 16'(v[2]), 16'h1);
    rd(1'b0, v); chk("R7 address data", 16'(v), 16'hE7);
    wr(1'b1, 8'hD4);                       // mode 11, filter off
    send_rx(8'h3B, 1'b1, 1'b0, 1'b1);
    rd(1'b1, v); chk("R7 unfiltered RI", 16'(v[0]), 16'h1);
    chk("R7 RB8 ninth 0", 16'(v[2]), 16'h0);
  endtask

  task automatic t_ren_off();
    logic [7:0] v;
    wr(1'b1, 8'h40);                       // REN=0
    send_rx(8'hF0, 1'b0, 1'b0, 1'b1);
    rd(1'b1, v); chk("R9 disabled no RI", 16'(v[0]), 16'h0);
    rd(1'b0, v); chk("R9 disabled data kept", 16'(v), 16'h3B);
    wr(1'b1, 8'h50);
    fork
      send_rx(8'h0F, 1'b0, 1'b0, 1'b1);
      begin
        repeat (4 * BIT) @(negedge clk);
        wr(1'b1, 8'h40);
      end
    join
    rd(1'b1, v); chk("R9 aborted no RI", 16'(v[0]), 16'h0);
    rd(1'b0, v); chk("R9 aborted data kept", 16'(v), 16'h3B);
  endtask

  task automatic t_mode0();
    logic [7:0] v;
    wr(1'b1, 8'h34);                       // mode 00, filter, REN, RB8=1
    send_rx(8'h5A, 1'b0, 1'b0, 1'b0);
    repeat (BIT) @(negedge clk);
    rd(1'b1, v); chk("R11 filter ignored RI", 16'(v[0]), 16'h1);
    chk("R11 RB8 untouched", 16'(v[2]), 16'h1);
    rd(1'b0, v); chk("R11 data", 16'(v), 16'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_tx(2'b01, 8'hB2, 1'b0);
    t_tx(2'b10, 8'h4D, 1'b1);
    t_tx(2'b11, 8'h96, 1'b0);
    t_tx_busy();
    t_rx_basic();
    t_rx_overrun();
    t_false_start();
    t_rx_8bit_filter();
    t_rx_nine();
    t_ren_off();
    t_mode0();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule